// File: doc/BRIEF.md
# Multiply-High-Unsigned Execution Unit

This unit executes a single register-register instruction: the unsigned multiply that keeps the upper word of a 32 by 32 product. A caller presents the 32-bit instruction word, two 64-bit source register values and the current summary-overflow flag, then pulses `start_i`. The unit checks that the instruction is this operation. It multiplies the low 32 bits of both sources as unsigned numbers over 32 shift-add cycles. It then raises `done_o` for one cycle, together with the destination register index and the zero-extended upper product word.

When the record flag in the instruction is set, the unit also returns a 4-bit condition field. This field compares the 32-bit result, read as a signed number, against zero. A high word of 0x80000000 or above therefore reports "less than" even though the product is unsigned. An instruction that fails decode completes at once, raises `illegal_o`, and requests no write.

Top module: `mulhu_exec_unit`

## Requirements
- R1: The instruction is legal only when `instr_i[31:26]` equals 31 and `instr_i[9:1]` equals 11. Otherwise `done_o` rises with `illegal_o` high, and `rd_we_o` and `cr_we_o` stay low.
- R2: For a legal instruction, `rd_data_o[31:0]` equals bits 63:32 of the unsigned product `src_a_i[31:0] * src_b_i[31:0]`, and `rd_data_o[63:32]` is zero. Bits 63:32 of both sources have no effect.
- R3: If the rising edge that accepts `start_i` is counted as edge 1, a legal instruction shows `done_o` high after edge 33 and an illegal one after edge 1.
- R4: `busy_o` is high from the accepting edge until the done cycle, inclusive. `start_i` is ignored while `busy_o` is high: the instruction in flight completes with its own operands and timing.
- R5: `rd_we_o` is high exactly in the done cycle of a legal instruction, and `rd_idx_o` then equals `instr_i[25:21]` as captured at start.
- R6: Bit `instr_i[10]`, the overflow-enable position, is ignored. It changes neither legality nor any result.
- R7: The record flag is `instr_i[0]`. `cr_we_o` is high in the done cycle of a legal instruction only when that flag was 1.
- R8: When `cr_we_o` is high, `cr_o[3]` is less-than (result bit 31 set), `cr_o[2]` is greater-than (bit 31 clear and result nonzero), `cr_o[1]` is equal (result zero), and `cr_o[0]` is `so_i` as sampled at start.
- R9: While `rst_n` is low at a clock edge, `busy_o`, `done_o`, `illegal_o`, `rd_we_o` and `cr_we_o` are low after that edge, and any operation in flight is abandoned.
- R10: `done_o` is high for exactly one cycle per accepted instruction.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation when not busy |
| instr_i | input | 32 | Instruction word, sampled with start |
| src_a_i | input | 64 | First source register value |
| src_b_i | input | 64 | Second source register value |
| so_i | input | 1 | Summary-overflow flag, sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Instruction failed decode (valid with done) |
| rd_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Destination write enable |
| rd_data_o | output | 64 | Destination write data |
| cr_we_o | output | 1 | Condition-field write enable |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions assume that `start_i` and the operand inputs are clean at each sampling edge. They also assume the caller reads the result only in the `done_o` cycle, and that reset is synchronous, with `rst_n` low for at least one edge before any checked activity. The stimulus drives every input on the falling edge, holds `start_i` for exactly one cycle per request, and asserts reset only through full low cycles. It raises `start_i` during a busy interval only on purpose, to exercise the ignore rule, and then checks that the in-flight result is undisturbed.

// File: rtl/mhu_pkg.sv
// Shared constants and types for the multiply-high-unsigned unit.
// Assumes the instruction field layout is fixed (MSB-first numbering mapped to [31:0]).
package mhu_pkg;
    localparam int unsigned INSTR_W    = 32;
    localparam logic [5:0]  PRIMARY_OP = 6'd31;
    localparam logic [8:0]  EXT_OP     = 9'd11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mhu_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } mhu_cr_t;
endpackage

// File: rtl/mhu_decode.sv
// Combinational decoder for the instruction word.
// Reports legality (primary and extended opcode match), the destination index
// and the record flag. The overflow-enable position and source index fields are
// not needed, since operand values arrive on their own ports.
module mhu_decode
    import mhu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output logic               legal_o,
    output logic [4:0]         rt_o,
    output logic               rc_o
);
    logic unused_fields;

    // Opcode match and field extraction
    always_comb begin
        legal_o = (instr_i[31:26] == PRIMARY_OP) && (instr_i[9:1] == EXT_OP);
        rt_o    = instr_i[25:21];
        rc_o    = instr_i[0];
    end

    assign unused_fields = ^instr_i[20:10];
endmodule

// File: rtl/mhu_shiftadd.sv
// Radix-2 shift-add unsigned multiplier datapath.
// load captures the operands; each step retires one multiplier bit from the LSB.
// After W steps prod_o holds the full 2W-bit product. Sequencing is up to the caller.
module mhu_shiftadd #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic [2*W-1:0] prod_o
);
    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] prod_q;
    logic [W:0]     sum;

    // Partial sum of the upper half and the conditionally selected multiplicand
    always_comb begin
        sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
    end

    // Operand load and one shift-add step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load_i) begin
            mcand_q <= mcand_i;
            prod_q  <= {{W{1'b0}}, mplier_i};
        end else if (step_i) begin
            prod_q  <= {sum, prod_q[W-1:1]};
        end
    end

    assign prod_o = prod_q;
endmodule

// File: rtl/mhu_cond.sv
// Builds the condition field from a W-bit result, read as a signed value,
// plus the summary-overflow copy. Purely combinational.
module mhu_cond
    import mhu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] result_i,
    input  logic         so_i,
    output mhu_cr_t      cr_o
);
    // Signed compare of the result against zero
    always_comb begin
        cr_o.lt = result_i[W-1];
        cr_o.eq = (result_i == '0);
        cr_o.gt = !result_i[W-1] && (result_i != '0);
        cr_o.so = so_i;
    end
endmodule

// File: rtl/mulhu_exec_unit.sv
// Multiply-high-unsigned execution unit.
// Accepts one instruction when idle and start is high, decodes it, runs HALF
// shift-add steps on the low halves of the sources, then pulses done for one
// cycle with the zero-extended upper product word. Assumes synchronous,
// active-low reset and a caller that reads results only in the done cycle.
module mulhu_exec_unit
    import mhu_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [XLEN-1:0]    src_a_i,
    input  logic [XLEN-1:0]    src_b_i,
    input  logic               so_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               illegal_o,
    output logic [4:0]         rd_idx_o,
    output logic               rd_we_o,
    output logic [XLEN-1:0]    rd_data_o,
    output logic               cr_we_o,
    output logic [3:0]         cr_o
);
    localparam int unsigned HALF  = XLEN / 2;
    localparam int unsigned CNT_W = $clog2(HALF);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(HALF - 1);

    mhu_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [4:0]       rt_q;
    logic             rc_q;
    logic             so_q;
    logic             illegal_q;

    logic             dec_legal;
    logic [4:0]       dec_rt;
    logic             dec_rc;
    logic             accept;
    logic [2*HALF-1:0] prod;
    mhu_cr_t          cr_val;
    logic             unused_upper;

    assign unused_upper = ^{src_a_i[XLEN-1:HALF], src_b_i[XLEN-1:HALF]};

    mhu_decode u_dec (
        .instr_i (instr_i),
        .legal_o (dec_legal),
        .rt_o    (dec_rt),
        .rc_o    (dec_rc)
    );

    // Start is honoured only in the idle state
    assign accept = start_i && (state_q == ST_IDLE);

    mhu_shiftadd #(.W(HALF)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .step_i   (state_q == ST_RUN),
        .mcand_i  (src_a_i[HALF-1:0]),
        .mplier_i (src_b_i[HALF-1:0]),
        .prod_o   (prod)
    );

    mhu_cond #(.W(HALF)) u_cond (
        .result_i (prod[2*HALF-1:HALF]),
        .so_i     (so_q),
        .cr_o     (cr_val)
    );

    // Sequencer: idle -> run for HALF steps -> one finish cycle; illegal skips run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            rt_q      <= '0;
            rc_q      <= 1'b0;
            so_q      <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    rt_q      <= dec_rt;
                    rc_q      <= dec_rc;
                    so_q      <= so_i;
                    illegal_q <= !dec_legal;
                    cnt_q     <= '0;
                    state_q   <= dec_legal ? ST_RUN : ST_FIN;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output view of the sequencer state and result
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_FIN);
        illegal_o = done_o && illegal_q;
        rd_we_o   = done_o && !illegal_q;
        cr_we_o   = rd_we_o && rc_q;
        rd_idx_o  = rt_q;
        rd_data_o = {{(XLEN-HALF){1'b0}}, prod[2*HALF-1:HALF]};
        cr_o      = cr_val;
    end
endmodule

// File: rtl/mhu_checker.sv
// Property checker for mulhu_exec_unit, attached by bind.
// Observes only the top-level ports; every property is disabled during reset.
module mhu_checker #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            illegal_o,
    input logic            rd_we_o,
    input logic [XLEN-1:0] rd_data_o,
    input logic            cr_we_o,
    input logic [3:0]      cr_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R10
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) illegal_o |-> (done_o && !rd_we_o && !cr_we_o)); // R1
    AST_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) rd_we_o |-> (done_o && !illegal_o)); // R5
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_we_o |-> (rd_data_o[XLEN-1:XLEN/2] == '0)); // R2
    AST_CR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cr_we_o |-> rd_we_o); // R7
    AST_CR_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cr_we_o |-> ($countones(cr_o[3:1]) == 1)); // R8
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R4
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> busy_o); // R4
endmodule

bind mulhu_exec_unit mhu_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .rd_we_o   (rd_we_o),
    .rd_data_o (rd_data_o),
    .cr_we_o   (cr_we_o),
    .cr_o      (cr_o)
);

// File: tb/sim_mulhu_exec_unit.sv
`timescale 1ns/1ps
module sim_mulhu_exec_unit;
    localparam int NV = 8;
    // Stimulus table: instruction, sources, summary-overflow, expected illegal
    localparam logic [31:0] V_INSTR [NV] = '{
        32'h7C60_0017, 32'h7CE0_0017, 32'h7FE0_0417, 32'h7C00_0016,
        32'h7D80_0017, 32'h7800_0017, 32'h7C00_0014, 32'h7C00_01D7};
    localparam logic [63:0] V_A [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_0000_0000, 64'h0000_0000_0001_0000, 64'h0000_0000_8000_0000,
        64'hAAAA_0000_DEAD_BEEF, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005, 64'h0000_0000_FFFF_0000};
    localparam logic [63:0] V_B [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0002,
        64'h5555_0000_CAFE_BABE, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0009, 64'h0000_0000_0001_0000};
    localparam logic V_SO  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic V_ILL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] src_a_i = '0;
    logic [63:0] src_b_i = '0;
    logic        so_i = 1'b0;
    logic        busy_o, done_o, illegal_o, rd_we_o, cr_we_o;
    logic [4:0]  rd_idx_o;
    logic [63:0] rd_data_o;
    logic [3:0]  cr_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    mulhu_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .so_i(so_i),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o),
        .rd_idx_o(rd_idx_o), .rd_we_o(rd_we_o), .rd_data_o(rd_data_o),
        .cr_we_o(cr_we_o), .cr_o(cr_o)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one instruction; if poke, raises start with other inputs mid-flight
    task automatic run_op(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                          input logic so, input logic exp_ill, input logic poke);
        logic [63:0] p;
        logic [31:0] hi;
        logic [3:0]  exp_cr;
        int n;
        p = {32'b0, a[31:0]} * {32'b0, b[31:0]};
        hi = p[63:32];
        exp_cr = {hi[31], !hi[31] && (hi != 0), hi == 0, so};
        @(negedge clk);
        instr_i = ins; src_a_i = a; src_b_i = b; so_i = so; start_i = 1'b1;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start_i = 1'b0;
            if (n == 2) chk(busy_o == 1'b1, "R4 busy during op", 64'(busy_o), 64'd1);
            if (poke && n == 5) begin
                instr_i = 32'h7800_0000; src_a_i = '1; src_b_i = 64'd3; so_i = ~so; start_i = 1'b1;
            end
            if (done_o) break;
        end
        chk(n == (exp_ill ? 1 : 33), "R3 latency", 64'(n), exp_ill ? 64'd1 : 64'd33);
        chk(illegal_o == exp_ill, "R1 illegal flag", 64'(illegal_o), 64'(exp_ill));
        chk(rd_we_o == !exp_ill, "R5 write enable", 64'(rd_we_o), 64'(!exp_ill));
        chk(cr_we_o == (!exp_ill && ins[0]), "R7 cr write enable", 64'(cr_we_o), 64'(!exp_ill && ins[0]));
        if (!exp_ill) begin
            chk(rd_data_o == {32'b0, hi}, "R2 result", rd_data_o, {32'b0, hi});
            chk(rd_idx_o == ins[25:21], "R5 dest index", 64'(rd_idx_o), 64'(ins[25:21]));
            if (ins[10]) chk(rd_data_o == {32'b0, hi}, "R6 OE bit ignored", rd_data_o, {32'b0, hi});
            if (ins[0]) chk(cr_o == exp_cr, "R8 condition field", 64'(cr_o), 64'(exp_cr));
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single pulse", 64'(done_o), 64'd0);
        chk(busy_o == 1'b0, "R4 idle after done", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(!busy_o && !done_o && !illegal_o && !rd_we_o && !cr_we_o, "R9 reset outputs",
            64'({busy_o, done_o, illegal_o, rd_we_o, cr_we_o}), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            run_op(V_INSTR[i], V_A[i], V_B[i], V_SO[i], V_ILL[i], 1'b0);

        // R4: start while busy is ignored
        run_op(32'h7CA0_0017, 64'h0000_0000_9000_0001, 64'h0000_0000_7000_0003, 1'b1, 1'b0, 1'b1);

        // R6: OE set versus clear on the same operands
        run_op(32'h7C40_0417, 64'h0000_0000_0002_0000, 64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b0);
        run_op(32'h7C40_0017, 64'h0000_0000_0002_0000, 64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b0);

        // R9: reset mid-operation abandons it
        @(negedge clk);
        instr_i = 32'h7C20_0017; src_a_i = 64'd7; src_b_i = 64'd9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy_o && !done_o && !rd_we_o, "R9 reset mid-op",
            64'({busy_o, done_o, rd_we_o}), 64'd0);
        rst_n = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (done_o) chk(1'b0, "R9 no done after abandon", 64'd1, 64'd0);
        end
        run_op(32'h7C20_0017, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 1'b0, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule